// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Interface

This block turns single requests from an internal requester into bus cycles on an external bus. The bus shares one 8-bit lane between the low address byte and the data byte. The upper address bits have their own output-only bus. Each request carries an address, write data, a direction and a memory/I-O selector. The unit first presents the address and marks that phase with a latch strobe. It then asserts one active-low read or write strobe, and it lengthens the data phase for as long as the external ready input stays low. When the cycle finishes, the unit hands back the read data together with a one-cycle completion pulse.

The shared lane is split into output value, output enable and input value, so the chip's I/O cell can build the bidirectional pad. A cycle has these states:

- one address clock;
- one strobe clock;
- any number of wait clocks;
- one completion clock, in which the strobe is still asserted.

After the cycle, the unit returns to idle and raises the done pulse.

Top module: `mux_bus_if`

## Requirements
- R1: While reset is asserted and in idle, `rd_n` and `wr_n` are 1, `ale` is 0, `ad_oe` is 0 and `done` is 0.
- R2: From the address clock through the completion clock, `ahi` equals bits [15:8] of the accepted address and does not change.
- R3: The address clock comes exactly one clock after a request is accepted. In it, `ale` is 1 for that single clock, `ad_oe` is 1 and `ad_o` equals bits [7:0] of the address.
- R4: `ale` is 0 whenever either strobe is asserted.
- R5: In the data phase exactly one strobe is low: `wr_n` when `req_write` was 1, and `rd_n` when it was 0.
- R6: `io_m` is 1 for an I/O transfer (`req_io`=1) and 0 for a memory transfer, and it holds for the whole cycle.
- R7: `ready` is sampled at the end of the strobe clock and at the end of each wait clock. Each low sample adds one more clock with the strobe asserted, so the strobe lasts N+2 clocks for N low samples.
- R8: In a write, `ad_oe` is 1 and `ad_o` carries the write data on every clock in which `wr_n` is low.
- R9: In a read, `ad_oe` is 0 throughout the data phase. `rd_data` holds the `ad_i` value sampled at the end of the last strobe clock, and is presented with `done`.
- R10: `done` is high for exactly one clock: the clock right after the strobe deasserts.
- R11: A request raised while a cycle is in progress is ignored and starts no address phase. A request raised in the `done` clock is accepted, because the unit is idle then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_addr | input | 16 | Transfer address |
| req_wdata | input | 8 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 8 | Captured read data |
| ahi | output | 8 | Upper address bus |
| ad_o | output | 8 | Shared lane, outgoing value |
| ad_oe | output | 1 | Shared lane output enable |
| ad_i | input | 8 | Shared lane, incoming value |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | Space indicator, 1 = I/O |
| ready | input | 1 | External ready, low stretches the data phase |

## Verification
Two things can fall in the same clock: the completion pulse of one cycle and the arrival of the next request. The driver provokes this by raising the next request in the very clock where it sees `done`. The scoreboard then expects that item's address phase on the following clock. The driver also raises foreign requests during the address and strobe clocks of a cycle. These are judged ignored if the monitor never sees an address phase for which no item is queued, and if the queue drains exactly.

// File: rtl/mbi_pkg.sv
package mbi_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_STRB,
      ST_WAIT,
      ST_LAST
   } bus_st_e;
endpackage

// File: rtl/mbi_seq.sv
module mbi_seq
   import mbi_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    req_valid,
   input  logic    ready,
   input  logic    is_write,
   output bus_st_e state,
   output logic    accept,
   output logic    capture,
   output logic    busy,
   output logic    addr_phase,
   output logic    data_phase,
   output logic    ale,
   output logic    rd_n,
   output logic    wr_n,
   output logic    done
);
   bus_st_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE: if (req_valid) nxt = ST_ADDR;
         ST_ADDR: nxt = ST_STRB;
         ST_STRB,
         ST_WAIT: nxt = ready ? ST_LAST : ST_WAIT;
         ST_LAST: nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         done  <= 1'b0;
      end else begin
         state <= nxt;
         done  <= (state == ST_LAST);
      end
   end

   assign accept     = (state == ST_IDLE) && req_valid;
   assign capture    = (state == ST_LAST);
   assign busy       = (state != ST_IDLE);
   assign addr_phase = (state == ST_ADDR);
   assign data_phase = (state == ST_STRB) || (state == ST_WAIT) || (state == ST_LAST);
   assign ale        = addr_phase;
   assign rd_n       = !(data_phase && !is_write);
   assign wr_n       = !(data_phase && is_write);

   AST_WAIT_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (((state == ST_STRB) || (state == ST_WAIT)) && !ready) |=> ((state == ST_WAIT) && (!rd_n || !wr_n))); // R7
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10
   AST_ADDR_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ADDR) |-> ($past(state) == ST_IDLE)); // R11
   AST_ALE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> !ale); // R3
endmodule

// File: rtl/mbi_datapath.sv
module mbi_datapath #(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 8,
   parameter bit RDATA_HOLD = 1'b1,
   localparam int HI_W      = ADDR_W - DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              capture,
   input  logic              done,
   input  logic              busy,
   input  logic              addr_phase,
   input  logic              data_phase,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              req_write,
   input  logic              req_io,
   input  logic [DATA_W-1:0] ad_i,
   output logic              is_write,
   output logic [HI_W-1:0]   ahi,
   output logic [DATA_W-1:0] ad_o,
   output logic              ad_oe,
   output logic              io_m,
   output logic [DATA_W-1:0] rd_data
);
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rdata_q;
   logic              wr_q;
   logic              io_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         wr_q    <= 1'b0;
         io_q    <= 1'b0;
      end else if (accept) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
         wr_q    <= req_write;
         io_q    <= req_io;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                rdata_q <= '0;
      else if (capture && !wr_q) rdata_q <= ad_i;
   end

   assign is_write = wr_q;
   assign ahi      = addr_q[ADDR_W-1:DATA_W];
   assign io_m     = io_q;
   assign ad_oe    = addr_phase || (data_phase && wr_q);
   assign ad_o     = addr_phase ? addr_q[DATA_W-1:0] : wdata_q;

   generate
      if (RDATA_HOLD) begin : g_rd_hold
         assign rd_data = rdata_q;
      end else begin : g_rd_pulse
         assign rd_data = done ? rdata_q : '0;
      end
   endgenerate

   AST_IO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(io_m)); // R6
   AST_AHI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(ahi)); // R2
   AST_IDLE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !ad_oe); // R1
endmodule

// File: rtl/mux_bus_if.sv
module mux_bus_if
   import mbi_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 8,
   parameter bit RDATA_HOLD = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [DATA_W-1:0]        req_wdata,
   input  logic                     req_write,
   input  logic                     req_io,
   output logic                     done,
   output logic [DATA_W-1:0]        rd_data,
   output logic [ADDR_W-DATA_W-1:0] ahi,
   output logic [DATA_W-1:0]        ad_o,
   output logic                     ad_oe,
   input  logic [DATA_W-1:0]        ad_i,
   output logic                     ale,
   output logic                     rd_n,
   output logic                     wr_n,
   output logic                     io_m,
   input  logic                     ready
);
   generate
      if (DATA_W < 1 || ADDR_W <= DATA_W) begin : g_bad_widths
         $error("mux_bus_if: ADDR_W must exceed DATA_W, and DATA_W must be at least 1");
      end
   endgenerate

   bus_st_e state;
   logic    accept, capture, busy, addr_phase, data_phase, is_write;

   mbi_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .ready      (ready),
      .is_write   (is_write),
      .state      (state),
      .accept     (accept),
      .capture    (capture),
      .busy       (busy),
      .addr_phase (addr_phase),
      .data_phase (data_phase),
      .ale        (ale),
      .rd_n       (rd_n),
      .wr_n       (wr_n),
      .done       (done)
   );

   mbi_datapath #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .RDATA_HOLD (RDATA_HOLD)
   ) u_dp (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .capture    (capture),
      .done       (done),
      .busy       (busy),
      .addr_phase (addr_phase),
      .data_phase (data_phase),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .req_write  (req_write),
      .req_io     (req_io),
      .ad_i       (ad_i),
      .is_write   (is_write),
      .ahi        (ahi),
      .ad_o       (ad_o),
      .ad_oe      (ad_oe),
      .io_m       (io_m),
      .rd_data    (rd_data)
   );

   AST_WR_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |-> ad_oe); // R8
   AST_RD_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !ad_oe); // R9
   AST_ALE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> (rd_n && wr_n)); // R4
   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STRB) |-> (rd_n != wr_n)); // R5
endmodule

// File: tb/tb_mux_bus_if.sv
`timescale 1ns/1ps
module tb_mux_bus_if;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [15:0] req_addr = '0;
   logic [7:0] req_wdata = '0;
   logic       req_write = 1'b0;
   logic       req_io = 1'b0;
   logic       ready = 1'b1;
   logic [7:0] ad_i = 8'h5A;
   logic       done, ad_oe, ale, rd_n, wr_n, io_m;
   logic [7:0] rd_data, ahi, ad_o;

   always #2 clk = ~clk;

   mux_bus_if dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_write(req_write), .req_io(req_io),
      .done(done), .rd_data(rd_data), .ahi(ahi), .ad_o(ad_o), .ad_oe(ad_oe),
      .ad_i(ad_i), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m), .ready(ready)
   );

   typedef struct {
      logic [15:0] addr;
      logic [7:0]  wdata;
      logic        wr;
      logic        io;
      int          waits;
      logic [7:0]  rdval;
   } item_t;

   item_t q[$];
   item_t cur;
   int    checks = 0;
   int    failures = 0;
   bit    mon_on = 1'b0;
   bit    in_cyc = 1'b0;
   int    scnt = 0;
   bit    prev_done = 1'b0;
   bit    prev_strb = 1'b0;
   logic  strb_now;

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Monitor: compares the bus against the head of the scoreboard queue
   always @(negedge clk) begin
      if (mon_on) begin
         strb_now = !rd_n || !wr_n;
         if (ale) begin
            if (q.size() == 0) begin
               chk(1'b0, "R11 address phase with no request queued", ahi, 0);
            end else begin
               cur    = q[0];
               in_cyc = 1'b1;
               scnt   = 0;
               chk(ahi == cur.addr[15:8], "R2 upper address", ahi, cur.addr[15:8]);
               chk(ad_oe && ad_o == cur.addr[7:0], "R3 low address on lane", ad_o, cur.addr[7:0]);
               chk(io_m == cur.io, "R6 space indicator", io_m, cur.io);
               chk(rd_n && wr_n, "R4 no strobe with latch strobe", {rd_n, wr_n}, 3);
            end
            ready = 1'b1;
            ad_i  = 8'h5A;
         end else if (in_cyc && strb_now) begin
            scnt++;
            chk(((!wr_n) == cur.wr) && ((!rd_n) == !cur.wr), "R5 strobe selection",
                {rd_n, wr_n}, cur.wr ? 2 : 1);
            chk(ahi == cur.addr[15:8], "R2 upper address held", ahi, cur.addr[15:8]);
            chk(io_m == cur.io, "R6 space indicator held", io_m, cur.io);
            if (cur.wr)
               chk(ad_oe && ad_o == cur.wdata, "R8 write data on lane", ad_o, cur.wdata);
            else
               chk(!ad_oe, "R9 lane released during read", ad_oe, 0);
            ready = (scnt > cur.waits);
            ad_i  = (scnt == cur.waits + 2) ? cur.rdval : ~cur.rdval;
         end else begin
            ready = 1'b1;
            ad_i  = 8'h5A;
         end
         if (done) begin
            if (!in_cyc) begin
               chk(1'b0, "R10 done outside a cycle", 1, 0);
            end else begin
               chk(!prev_done, "R10 done lasts one clock", prev_done, 0);
               chk(prev_strb && !strb_now, "R10 done right after strobe release",
                   {prev_strb, strb_now}, 2);
               chk(scnt == cur.waits + 2, "R7 strobe length", scnt, cur.waits + 2);
               if (!cur.wr)
                  chk(rd_data == cur.rdval, "R9 captured read data", rd_data, cur.rdval);
               void'(q.pop_front());
               in_cyc = 1'b0;
            end
         end
         prev_done = done;
         prev_strb = strb_now;
      end
   end

   // Driver: queues the expected item and raises the request
   task automatic xfer(logic [15:0] a, logic [7:0] wd, bit wr, bit io, int w,
                       logic [7:0] rv, bit inject);
      item_t it;
      it.addr = a; it.wdata = wd; it.wr = wr; it.io = io; it.waits = w; it.rdval = rv;
      q.push_back(it);
      req_valid = 1'b1; req_addr = a; req_wdata = wd; req_write = wr; req_io = io;
      @(negedge clk);
      req_valid = 1'b0;
      chk(ale == 1'b1, "R3 address phase one clock after request", ale, 1);
      if (inject) begin
         // R11: foreign request during address and strobe clocks must be ignored
         req_valid = 1'b1; req_addr = 16'hDEAD; req_write = ~wr; req_io = ~io;
         repeat (2) @(negedge clk);
         req_valid = 1'b0;
      end
      while (!done) @(negedge clk);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired, run hung actual=0 expected=1");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(rd_n && wr_n, "R1 strobes high in reset", {rd_n, wr_n}, 3);
      chk(!ale, "R1 latch strobe low in reset", ale, 0);
      chk(!ad_oe, "R1 lane released in reset", ad_oe, 0);
      chk(!done, "R1 done low in reset", done, 0);
      rst_n = 1'b1;
      mon_on = 1'b1;
      @(negedge clk);
      chk(rd_n && wr_n && !ale && !ad_oe, "R1 idle after reset", {rd_n, wr_n, ale, ad_oe}, 12);
      xfer(16'h12A4, 8'h3C, 1'b1, 1'b0, 0, 8'h00, 1'b0);
      xfer(16'h8001, 8'h00, 1'b0, 1'b0, 0, 8'hC7, 1'b0);
      xfer(16'hFF10, 8'h81, 1'b1, 1'b1, 3, 8'h00, 1'b0);
      xfer(16'h00FE, 8'h00, 1'b0, 1'b1, 1, 8'h69, 1'b1);
      repeat (3) @(negedge clk);
      xfer(16'h4321, 8'hE0, 1'b0, 1'b0, 5, 8'h96, 1'b0);
      for (int i = 0; i < 12; i++) begin
         xfer(16'(i * 16'h2F1B + 16'h0404), 8'(i * 37 + 5), i[0], i[1], i % 4,
              8'(i * 53 + 9), (i % 3) == 0);
         if (i == 6) repeat (2) @(negedge clk);
      end
      repeat (4) @(negedge clk);
      chk(q.size() == 0, "R11 every queued request completed once", q.size(), 0);
      chk(rd_n && wr_n && !ale && !ad_oe && !done, "R1 idle at end",
          {rd_n, wr_n, ale, ad_oe, done}, 24);
      summary();
      $finish;
   end
endmodule